// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects latched event flags for a four-port power-sourcing controller and turns them into one active-low interrupt line. Single-cycle event pulses arrive in groups: power-enable change, power-good change, detection done, classification done, current-limit violation, load disconnect, startup failure and supply fault. Each pulse sets a bit in one of five event registers, and that bit stays set until software clears it.

An 8-bit read-only summary reduces each event register, or one nibble of it, to a single bit. Each summary bit is ANDed with its mask bit, the results are ORed together, and the outcome is gated by a global enable to form the registered interrupt. A synchronous register port gives software access to the summary, the mask, the enable, the event registers and a self-clearing clear-all command. Each event register can be read without side effects at one address and read-and-cleared at the next address. The reset value of the mask follows an auto-mode input that the clock samples while reset is held.

Top module: `pse_irq_agg`

## Requirements
- R1: After reset, the summary (address 0x00) reads 0x00, the enable register (0x02) reads 0x00, every event register reads 0x00, and irq_no is 1.
- R2: The mask (0x01, read/write) resets to 0xE4 when auto_mode_i is high during reset and to 0x00 when it is low. This is pattern bits 7,6,5,2 equal to the auto level and all other bits 0.
- R3: A one-cycle pulse on an event input sets its event bit, and the bit stays set. Reads at the peek addresses have no effect on it. The event registers are: power 0x08 = {pgood_i, pwr_en_i}, det/class 0x0A = {cls_i, det_i}, fault 0x0C = {disc_i, ilim_i}, startup 0x0E, supply 0x10.
- R4: The summary bits are formed as follows: bit7 = OR of supply[7:0]; bit6 = OR of startup[7:0]; bit5 = OR of fault[3:0]; bit4 = OR of det/class[7:4]; bit3 = OR of det/class[3:0]; bit2 = OR of fault[7:4]; bit1 = OR of power[7:4]; bit0 = OR of power[3:0].
- R5: When the enable bit (0x02 bit 7) is 1 and summary & mask is nonzero, irq_no is 0 one clock after that condition holds. It returns to 1 one clock after the condition ends.
- R6: A summary bit whose mask bit is 0 does not drive irq_no low.
- R7: While the enable bit is 0, irq_no stays 1.
- R8: A read at an event register's clear address (peek address + 1) returns the current value and clears the register after the read.
- R9: An event pulse that arrives in the same cycle as a clear (a clear-on-read or a clear-all) leaves its bit set.
- R10: Writing 1 to bit 7 of the command register (0x03) clears all event registers, and so also the summary, in one cycle. The command register always reads 0x00.
- R11: Writes to the summary address and to the event register addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_mode_i | input | 1 | Auto-mode level that selects the mask reset value |
| pwr_en_i | input | 4 | Power-enable change pulses, one per port |
| pgood_i | input | 4 | Power-good change pulses |
| det_i | input | 4 | Detection done pulses |
| cls_i | input | 4 | Classification done pulses |
| ilim_i | input | 4 | Current-limit violation pulses |
| disc_i | input | 4 | Load disconnect pulses |
| start_i | input | 8 | Startup failure pulses |
| supply_i | input | 8 | Supply fault pulses |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered one clock after the read strobe |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Some properties are checked on every cycle. The event bits are checked for stickiness, for emptying on a clear, and for the pulse winning over a simultaneous clear. The interrupt output is checked for its one-cycle response to enable, mask and summary, and the command register is checked to read as zero. Other behaviour can only be shown by the bench's scenarios. These are the nibble-to-summary mapping, the mask reset value for both auto levels, writes to read-only addresses having no effect, and the value a clear-on-read returns before the register empties.

// File: rtl/pse_irq_pkg.sv
package pse_irq_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned N_EVT    = 5;
  localparam logic [ADDR_W-1:0] A_SUM  = 5'h00;
  localparam logic [ADDR_W-1:0] A_MASK = 5'h01;
  localparam logic [ADDR_W-1:0] A_CFG  = 5'h02;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'h03;
  localparam logic [ADDR_W-1:0] A_EVT0 = 5'h08;

  // event register index
  localparam int unsigned EV_PWR = 0;
  localparam int unsigned EV_DC  = 1;
  localparam int unsigned EV_FLT = 2;
  localparam int unsigned EV_ST  = 3;
  localparam int unsigned EV_SUP = 4;

  function automatic logic [7:0] mask_rst(input logic a);
    return {a, a, a, 1'b0, 1'b0, a, 1'b0, 1'b0};
  endfunction
endpackage

// File: rtl/pse_irq_evt_reg.sv
module pse_irq_evt_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pulse_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (clr_i ? '0 : q) | pulse_i;  // new event wins over clear
  end

  assign q_o = q;

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));  // R3
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i != '0) |=> ((q_o & $past(pulse_i)) == $past(pulse_i)));  // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && pulse_i == '0) |=> (q_o == '0));  // R8
endmodule

// File: rtl/pse_irq_summary.sv
module pse_irq_summary #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_EVT = 5
) (
  input  logic [N_EVT-1:0][W-1:0] ev_i,
  output logic [7:0]              sum_o
);
  import pse_irq_pkg::*;
  localparam int unsigned H = W / 2;

  always_comb begin
    sum_o[7] = |ev_i[EV_SUP];
    sum_o[6] = |ev_i[EV_ST];
    sum_o[5] = |ev_i[EV_FLT][H-1:0];
    sum_o[4] = |ev_i[EV_DC][W-1:H];
    sum_o[3] = |ev_i[EV_DC][H-1:0];
    sum_o[2] = |ev_i[EV_FLT][W-1:H];
    sum_o[1] = |ev_i[EV_PWR][W-1:H];
    sum_o[0] = |ev_i[EV_PWR][H-1:0];
  end
endmodule

// File: rtl/pse_irq_gate.sv
module pse_irq_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] sum_i,
  input  logic [7:0] mask_i,
  input  logic       en_i,
  output logic       irq_no
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i & (|(sum_i & mask_i));
  end

  assign irq_no = ~irq_q;

  AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (sum_i & mask_i) != 8'h00) |=> !irq_no);  // R5
  AST_MASK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sum_i & mask_i) == 8'h00) |=> irq_no);  // R6
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> irq_no);  // R7
endmodule

// File: rtl/pse_irq_agg.sv
module pse_irq_agg #(
  parameter int unsigned N_PORTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        auto_mode_i,
  input  logic [N_PORTS-1:0]          pwr_en_i,
  input  logic [N_PORTS-1:0]          pgood_i,
  input  logic [N_PORTS-1:0]          det_i,
  input  logic [N_PORTS-1:0]          cls_i,
  input  logic [N_PORTS-1:0]          ilim_i,
  input  logic [N_PORTS-1:0]          disc_i,
  input  logic [2*N_PORTS-1:0]        start_i,
  input  logic [2*N_PORTS-1:0]        supply_i,
  input  logic [pse_irq_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic                        reg_wr_i,
  input  logic                        reg_rd_i,
  input  logic [7:0]                  reg_wdata_i,
  output logic [7:0]                  reg_rdata_o,
  output logic                        irq_no
);
  import pse_irq_pkg::*;
  localparam int unsigned EW = 2 * N_PORTS;

  logic [N_EVT-1:0][EW-1:0] pulse_v;
  logic [N_EVT-1:0][EW-1:0] ev_q;
  logic [N_EVT-1:0]         clr_v;
  logic [7:0]               sum;
  logic [7:0]               mask_q;
  logic                     en_q;
  logic                     auto_q;
  logic                     clr_all;
  logic [7:0]               rdata_q;
  logic [7:0]               rd_mux;

  assign pulse_v[EV_PWR] = {pgood_i, pwr_en_i};
  assign pulse_v[EV_DC]  = {cls_i, det_i};
  assign pulse_v[EV_FLT] = {disc_i, ilim_i};
  assign pulse_v[EV_ST]  = start_i;
  assign pulse_v[EV_SUP] = supply_i;

  assign clr_all = reg_wr_i && (reg_addr_i == A_CMD) && reg_wdata_i[7];

  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    localparam logic [ADDR_W-1:0] A_CLR = A_EVT0 + ADDR_W'(2*k + 1);
    assign clr_v[k] = clr_all || (reg_rd_i && reg_addr_i == A_CLR);
    pse_irq_evt_reg #(.W(EW)) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(pulse_v[k]),
      .clr_i  (clr_v[k]),
      .q_o    (ev_q[k])
    );
  end

  pse_irq_summary #(.W(EW), .N_EVT(N_EVT)) u_sum (
    .ev_i (ev_q),
    .sum_o(sum)
  );

  // auto level sampled continuously, including while reset is held
  always_ff @(posedge clk_i) auto_q <= auto_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= mask_rst(auto_q);
      en_q   <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i;
      if (reg_addr_i == A_CFG)  en_q   <= reg_wdata_i[7];
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (reg_addr_i)
      A_SUM:   rd_mux = sum;
      A_MASK:  rd_mux = mask_q;
      A_CFG:   rd_mux = {en_q, 7'b0};
      default: begin
        for (int k = 0; k < int'(N_EVT); k++) begin
          if (reg_addr_i == A_EVT0 + ADDR_W'(2*k) || reg_addr_i == A_EVT0 + ADDR_W'(2*k + 1))
            rd_mux = 8'(ev_q[k]);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= 8'h00;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;

  pse_irq_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sum_i (sum),
    .mask_i(mask_q),
    .en_i  (en_q),
    .irq_no(irq_no)
  );

  AST_CMD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_CMD) |=> (reg_rdata_o == 8'h00));  // R10
  AST_CLR_ALL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all && start_i == '0 && supply_i == '0) |=> (ev_q[EV_ST] == '0 && ev_q[EV_SUP] == '0));  // R10
endmodule

// File: tb/tb_pse_irq_agg.sv
module tb_pse_irq_agg;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic auto_mode_i = 1'b1;
  logic [3:0] pwr_en_i = '0, pgood_i = '0, det_i = '0, cls_i = '0, ilim_i = '0, disc_i = '0;
  logic [7:0] start_i = '0, supply_i = '0;
  logic [4:0] reg_addr_i = '0;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic irq_no;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  pse_irq_agg dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result with the scoreboard
  always @(posedge clk_i) begin
    if (rst_ni && reg_rd_i) begin
      #1;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    reg_addr_i = a; reg_rd_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic clr_pulses();
    pwr_en_i = '0; pgood_i = '0; det_i = '0; cls_i = '0;
    ilim_i = '0; disc_i = '0; start_i = '0; supply_i = '0;
  endtask

  task automatic do_reset(input logic a);
    auto_mode_i = a; rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk_i);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk_i);
    do_reset(1'b1);
    chk("R1 irq_no after reset", {7'b0, irq_no}, 8'h01);
    rd(5'h00, 8'h00, "R1 summary");
    rd(5'h02, 8'h00, "R1 enable");
    rd(5'h08, 8'h00, "R1 power events");
    rd(5'h10, 8'h00, "R1 supply events");
    rd(5'h01, 8'hE4, "R2 mask auto high");

    // power-enable port 1
    pwr_en_i[1] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h08, 8'h02, "R3 peek power");
    rd(5'h08, 8'h02, "R3 peek power again");
    rd(5'h00, 8'h01, "R4 summary bit0");
    chk("R7 enable off", {7'b0, irq_no}, 8'h01);

    wr(5'h02, 8'h80);
    @(negedge clk_i);
    chk("R6 masked bit0", {7'b0, irq_no}, 8'h01);
    wr(5'h01, 8'h01);
    chk("R5 one clock after mask", {7'b0, irq_no}, 8'h01);
    @(negedge clk_i);
    chk("R5 irq asserted", {7'b0, irq_no}, 8'h00);
    wr(5'h02, 8'h00);
    @(negedge clk_i);
    chk("R7 enable cleared", {7'b0, irq_no}, 8'h01);
    wr(5'h02, 8'h80);
    @(negedge clk_i);
    chk("R5 re-enabled", {7'b0, irq_no}, 8'h00);

    rd(5'h09, 8'h02, "R8 clear read value");
    rd(5'h08, 8'h00, "R8 power cleared");
    chk("R5 irq released", {7'b0, irq_no}, 8'h01);
    rd(5'h00, 8'h00, "R8 summary cleared");

    // mapping
    det_i[2] = 1'b1; cls_i[0] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h0A, 8'h14, "R3 det/class reg");
    rd(5'h00, 8'h18, "R4 bits4,3");
    ilim_i[3] = 1'b1; disc_i[1] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h0C, 8'h28, "R3 fault reg");
    rd(5'h00, 8'h3C, "R4 bits5,2");
    pgood_i[0] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h00, 8'h3E, "R4 bit1");
    start_i[5] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h00, 8'h7E, "R4 bit6");
    supply_i[7] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h00, 8'hFE, "R4 bit7");
    pwr_en_i[3] = 1'b1; @(negedge clk_i); clr_pulses();
    rd(5'h00, 8'hFF, "R4 all bits");

    wr(5'h00, 8'h00);
    rd(5'h00, 8'hFF, "R11 summary write ignored");
    wr(5'h08, 8'h00);
    rd(5'h08, 8'h18, "R11 event write ignored");

    wr(5'h03, 8'h80);
    rd(5'h00, 8'h00, "R10 clear-all summary");
    rd(5'h10, 8'h00, "R10 clear-all supply");
    rd(5'h03, 8'h00, "R10 command reads zero");

    // event collides with clear-on-read
    supply_i[0] = 1'b1; @(negedge clk_i); clr_pulses();
    supply_i[2] = 1'b1;
    rd(5'h11, 8'h01, "R9 clear read value");
    clr_pulses();
    rd(5'h10, 8'h04, "R9 event wins clear-on-read");
    // event collides with clear-all
    start_i[1] = 1'b1;
    wr(5'h03, 8'h80);
    clr_pulses();
    rd(5'h0E, 8'h02, "R9 event wins clear-all");
    rd(5'h10, 8'h00, "R10 supply cleared");

    do_reset(1'b0);
    rd(5'h01, 8'h00, "R2 mask auto low");
    chk("R1 irq_no after second reset", {7'b0, irq_no}, 8'h01);
    rd(5'h0E, 8'h00, "R1 startup cleared by reset");

    @(negedge clk_i);
    finish_run();
  end
endmodule